// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a single pulse-width-modulated output. An 8-bit timer counts up to a programmable period value and then restarts. The timer advances once every four input clocks times a selectable prescale ratio of 1, 4 or 16. Software-side writes go through three write-enabled ports: the period value, an 8-bit coarse duty value and a 2-bit fine duty value. The two duty parts join into one 10-bit duty number, coarse bits on top.

The duty number reaches the comparator only through a shadow register. The shadow loads on the last clock of each period, and continuously while the block is disabled. A write that lands mid-period therefore never changes the current waveform. The comparator works on the 8-bit timer extended by two fine bits, which are the top two bits of the active prescale step. This gives 10-bit duty resolution on an 8-bit period.

The output rises at the start of every period and falls on the first clock at which the extended timer equals the shadow duty. A one-cycle period-match pulse marks each period end, so a period counter or postscaler can sit outside the block.

Top module: `pwm10_gen`

## Requirements
- R1: The 10-bit duty value is {coarse[7:0], fine[1:0]}. The shadow value is visible on `shadow_duty_o`.
- R2: Duty writes are accepted at any time. While enabled, `shadow_duty_o` changes only on the clock edge that ends a period.
- R3: Prescale select 2'b00 gives ratio 1, 2'b01 gives ratio 4, and 2'b10 or 2'b11 gives ratio 16. One period lasts (period + 1) × 4 × ratio clocks.
- R4: The output is high from the first clock of a period. It goes low from the first clock at which {timer, fine bits} equals the shadow duty, so it is high for duty × ratio clocks.
- R5: A shadow duty of zero keeps the output low for the whole period.
- R6: A shadow duty of (period + 1) × 4 or more keeps the output high for the whole period.
- R7: `period_match_o` is a one-cycle pulse on the last clock of every period.
- R8: While `en_i` is low, the output and the match pulse stay low and the counters are held at zero. The first period after enable starts at count zero with a freshly loaded duty.
- R9: A duty write on the match clock edge is not taken by that edge's shadow load. It takes effect one period later.
- R10: After reset, all registers are zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| ps_sel_i | input | 2 | Prescale select (00:1, 01:4, 1x:16) |
| per_we_i | input | 1 | Period register write enable |
| per_d_i | input | 8 | Period register write data |
| duty_hi_we_i | input | 1 | Coarse duty write enable |
| duty_hi_d_i | input | 8 | Coarse duty data (duty bits 9:2) |
| duty_lo_we_i | input | 1 | Fine duty write enable |
| duty_lo_d_i | input | 2 | Fine duty data (duty bits 1:0) |
| pwm_o | output | 1 | PWM waveform |
| period_match_o | output | 1 | One-cycle pulse on the last clock of a period |
| shadow_duty_o | output | 10 | Current shadow duty, read-only |

## Verification
A duty register write and the shadow load can fall on the same clock edge, the one that ends a period. The bench provokes this by asserting the duty write enables in the cycle where `period_match_o` is high. It then measures the high time of the next two periods. The first must still show the old duty and the second the new one. A separate case writes mid-period and confirms that `shadow_duty_o` holds and that the running period keeps its old high time.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int TMR_W     = 8;
  localparam int FINE_W    = 2;
  localparam int PS_LEVELS = 3;
  localparam int SEL_W     = 2;
  localparam int DUTY_W    = TMR_W + FINE_W;
  typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/pwm10_prescale.sv
module pwm10_prescale
  import pwm10_pkg::*;
#(
  parameter int FW = FINE_W,
  parameter int LV = PS_LEVELS,
  parameter int SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [SW-1:0] sel_i,
  output logic          tick_o,
  output logic [FW-1:0] fine_o
);
  localparam int CW = FW * LV;

  logic [CW-1:0] cnt_q;
  logic [LV-1:0] tick_l;
  logic [FW-1:0] fine_l [LV];
  logic [SW-1:0] idx;

  // level k: step of 2^(FW*(k+1)) clocks, fine bits are the top FW bits of the step
  for (genvar k = 0; k < LV; k++) begin : g_lvl
    assign tick_l[k] = &cnt_q[FW*(k+1)-1:0];
    assign fine_l[k] = cnt_q[FW*k +: FW];
  end

  always_comb begin
    idx    = (sel_i >= SW'(LV)) ? SW'(LV-1) : sel_i;
    tick_o = tick_l[idx];
    fine_o = fine_l[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_FINE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (&fine_o)) else $error("tick outside last fine step"); // R3
endmodule

// File: rtl/pwm10_timer.sv
module pwm10_timer
  import pwm10_pkg::*;
#(
  parameter int TW = TMR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [TW-1:0] per_i,
  output logic [TW-1:0] timer_o,
  output logic          match_o
);
  logic [TW-1:0] timer_q;

  // >= so a period lowered below the running count still wraps
  assign match_o = en_i & tick_i & (timer_q >= per_i);
  assign timer_o = timer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      timer_q <= '0;
    else if (!en_i)   timer_q <= '0;
    else if (match_o) timer_q <= '0;
    else if (tick_i)  timer_q <= timer_q + 1'b1;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> (timer_q == '0)) else $error("timer did not restart"); // R3
  AST_MATCH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o) else $error("match pulse longer than one cycle"); // R7
endmodule

// File: rtl/pwm10_duty.sv
module pwm10_duty
  import pwm10_pkg::*;
#(
  parameter int TW = TMR_W,
  parameter int FW = FINE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_we_i,
  input  logic [TW-1:0]    hi_d_i,
  input  logic             lo_we_i,
  input  logic [FW-1:0]    lo_d_i,
  input  logic             load_i,
  output logic [TW+FW-1:0] shadow_o
);
  logic [TW-1:0]    hi_q;
  logic [FW-1:0]    lo_q;
  logic [TW+FW-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      lo_q     <= '0;
      shadow_q <= '0;
    end else begin
      if (hi_we_i) hi_q <= hi_d_i;
      if (lo_we_i) lo_q <= lo_d_i;
      if (load_i)  shadow_q <= {hi_q, lo_q};
    end
  end

  assign shadow_o = shadow_q;

  AST_SHADOW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(shadow_q)) else $error("shadow changed mid-period"); // R2
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SEL_W-1:0]  ps_sel_i,
  input  logic              per_we_i,
  input  logic [TMR_W-1:0]  per_d_i,
  input  logic              duty_hi_we_i,
  input  logic [TMR_W-1:0]  duty_hi_d_i,
  input  logic              duty_lo_we_i,
  input  logic [FINE_W-1:0] duty_lo_d_i,
  output logic              pwm_o,
  output logic              period_match_o,
  output logic [DUTY_W-1:0] shadow_duty_o
);
  logic [TMR_W-1:0]  per_q;
  logic [TMR_W-1:0]  timer;
  logic [FINE_W-1:0] fine;
  logic              tick;
  logic              match;
  duty_t             shadow;
  duty_t             pos;
  logic              hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       per_q <= '0;
    else if (per_we_i) per_q <= per_d_i;
  end

  pwm10_prescale #(.FW(FINE_W), .LV(PS_LEVELS), .SW(SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sel_i  (ps_sel_i),
    .tick_o (tick),
    .fine_o (fine)
  );

  pwm10_timer #(.TW(TMR_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick),
    .per_i   (per_q),
    .timer_o (timer),
    .match_o (match)
  );

  pwm10_duty #(.TW(TMR_W), .FW(FINE_W)) u_duty (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hi_we_i  (duty_hi_we_i),
    .hi_d_i   (duty_hi_d_i),
    .lo_we_i  (duty_lo_we_i),
    .lo_d_i   (duty_lo_d_i),
    .load_i   (match | ~en_i),
    .shadow_o (shadow)
  );

  assign pos = {timer, fine};

  // hold_q: set at period start, cleared once the compare point has passed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= 1'b0;
    else if (!en_i || match)  hold_q <= 1'b1;
    else if (pos == shadow)   hold_q <= 1'b0;
  end

  assign pwm_o          = en_i & hold_q & (pos != shadow);
  assign period_match_o = match;
  assign shadow_duty_o  = shadow;

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow == '0) |-> !pwm_o) else $error("output high with zero duty"); // R5
  AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && match && (timer != '0)) |=> (en_i && shadow != '0) == pwm_o || !en_i)
    else $error("period did not start high"); // R4
endmodule

// File: tb/pwm10_gen_tb.sv
module pwm10_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] sel = '0;
  logic       per_we = 1'b0;
  logic [7:0] per_d = '0;
  logic       hi_we = 1'b0;
  logic [7:0] hi_d = '0;
  logic       lo_we = 1'b0;
  logic [1:0] lo_d = '0;
  logic       pwm;
  logic       pm;
  logic [9:0] shadow;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pwm10_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ps_sel_i(sel),
    .per_we_i(per_we), .per_d_i(per_d),
    .duty_hi_we_i(hi_we), .duty_hi_d_i(hi_d),
    .duty_lo_we_i(lo_we), .duty_lo_d_i(lo_d),
    .pwm_o(pwm), .period_match_o(pm), .shadow_duty_o(shadow)
  );

  localparam int NV = 9;
  localparam int V_SEL [NV] = '{0, 0, 0, 0, 0, 1, 2, 0, 3};
  localparam int V_PER [NV] = '{7, 7, 7, 7, 7, 3, 1, 0, 2};
  localparam int V_DUTY[NV] = '{10, 0, 31, 32, 1023, 5, 3, 2, 7};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : 16;
  endfunction

  task automatic cfg(input int s, input int p, input int d);
    @(negedge clk);
    en = 1'b0;
    sel = 2'(s);
    per_d = 8'(p); per_we = 1'b1;
    hi_d = 8'(d >> 2); hi_we = 1'b1;
    lo_d = 2'(d); lo_we = 1'b1;
    @(negedge clk);
    per_we = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_match();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!pm && guard < 5000);
  endtask

  // call at the negedge of a match cycle; counts cycles up to and including the next match
  task automatic run_period(input int mid_at, input int new_duty, input int sh_exp,
                            output int len, output int hi);
    len = 0;
    hi = 0;
    do begin
      @(negedge clk);
      hi_we = 1'b0; lo_we = 1'b0; per_we = 1'b0;
      len++;
      hi += int'(pwm);
      if (len == mid_at) begin
        hi_d = 8'(new_duty >> 2); hi_we = 1'b1;
        lo_d = 2'(new_duty); lo_we = 1'b1;
      end
      if (mid_at >= 0 && len == mid_at + 2)
        chk("R2 shadow held mid-period", int'(shadow), sh_exp);
    end while (!pm && len < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len, hi, first, per_len, exp_hi;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 pwm at reset", int'(pwm), 0);
    chk("R10 match at reset", int'(pm), 0);
    chk("R10 shadow at reset", int'(shadow), 0);
    rst_n = 1'b1;

    // R1 duty composition, shadow follows while disabled
    cfg(0, 7, (8'hA5 << 2) | 2);
    chk("R1 shadow = {coarse,fine}", int'(shadow), 662);

    // R8 disabled: outputs stay low
    begin
      int hs = 0, ms = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        hs += int'(pwm);
        ms += int'(pm);
      end
      chk("R8 pwm low while disabled", hs, 0);
      chk("R8 match low while disabled", ms, 0);
    end

    // vector table: R3 period length, R4/R5/R6 high time
    for (int v = 0; v < NV; v++) begin
      cfg(V_SEL[v], V_PER[v], V_DUTY[v]);
      en = 1'b1;
      wait_match();
      run_period(-1, 0, 0, len, hi);
      per_len = (V_PER[v] + 1) * 4 * ratio(V_SEL[v]);
      exp_hi = ((V_DUTY[v] < (V_PER[v] + 1) * 4) ? V_DUTY[v] : (V_PER[v] + 1) * 4) * ratio(V_SEL[v]);
      chk("R3 period length", len, per_len);
      chk((V_DUTY[v] == 0) ? "R5 zero duty high time" :
          (exp_hi == per_len) ? "R6 full duty high time" : "R4 high time", hi, exp_hi);
    end

    // R8 first period after enable uses fresh duty, starts at count zero
    cfg(0, 7, 13);
    en = 1'b1;
    #1;
    first = int'(pwm);
    run_period(-1, 0, 0, len, hi);
    chk("R8 first period length", len + 1, 32);
    chk("R8 first period high time", hi + first, 13);

    // R2 mid-period write: current period keeps old duty, next gets new
    cfg(0, 7, 10);
    en = 1'b1;
    wait_match();
    run_period(3, 20, 10, len, hi);
    chk("R2 old duty kept this period", hi, 10);
    run_period(-1, 0, 0, len, hi);
    chk("R2 new duty next period", hi, 20);

    // R9 write on the match edge: one period late
    hi_d = 8'd2; hi_we = 1'b1;
    lo_d = 2'd0; lo_we = 1'b1;
    run_period(-1, 0, 0, len, hi);
    chk("R9 same-edge write not taken", hi, 20);
    chk("R7 match ends the period", int'(pm), 1);
    run_period(-1, 0, 0, len, hi);
    chk("R9 write taken one period later", hi, 8);
    chk("R7 period length between pulses", len, 32);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule